// File: doc/BRIEF.md
# Sticky Reset-Cause Status Register

This block keeps a byte of flags that records every reason the chip has been reset since the last deep reset. A power-on, a low-voltage event or a wakeup from a low-power mode counts as a deep reset. Each reset source delivers a one-cycle pulse, and the pulse sets its own flag. The flag then stays set through any number of later warm resets. Software clears a flag by writing a one to its bit through a single-register select, read and write port. A deep-reset event loads the register with a fixed starting pattern instead.

The flops are reset only by the asynchronous `rst_n`, which stands for the power-on condition. Warm reset causes never reset the flops; they only add bits. A power-on always reports two flags together: the power-on flag, and the low-voltage flag, because the supply was below its threshold while it ramped.

Bit layout: 7 power-on, 6 external reset pin, 5 watchdog, 4 reserved, 3 PLL loss-of-lock, 2 loss-of-clock, 1 low-voltage, 0 low-power wakeup.

Top module: `rst_cause_sticky`

## Requirements
- R1: While `rst_n` is low, and after it is released, the register reads 0x82: bit 7 and bit 1 are set.
- R2: Bit 4 always reads 0. A write to bit 4 has no effect.
- R3: A write with `reg_sel` and `reg_wr` high clears every flag whose `reg_wdata` bit is 1, from the next clock edge on. A `reg_wdata` bit of 0 leaves its flag unchanged.
- R4: Each warm pulse sets its flag at the next edge and leaves all other flags as they were. The pulses and their bits are `pin_evt` bit 6, `wdog_evt` bit 5, `lol_evt` bit 3 and `loc_evt` bit 2.
- R5: A `wdog_evt` pulse while `wdog_en` is low has no effect.
- R6: If a source pulse and a write-one clear of the same bit arrive in the same cycle, the flag ends up set.
- R7: At the next edge, a deep event loads the whole register, overriding warm pulses and writes in the same cycle. The loaded value is 0x82 for `por_evt`, 0x02 for `lvd_evt` and 0x01 for `wake_evt`. When several deep events arrive together, `por_evt` takes priority over `lvd_evt`, and `lvd_evt` over `wake_evt`.
- R8: `reg_rdata` shows the flags while `reg_sel` is high and 0 while it is low. Reading never changes the flags.
- R9: A write with `reg_sel` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| por_evt | input | 1 | Power-on deep-reset pulse |
| lvd_evt | input | 1 | Low-voltage deep-reset pulse |
| wake_evt | input | 1 | Low-power wakeup deep-reset pulse |
| pin_evt | input | 1 | External reset pin pulse |
| wdog_evt | input | 1 | Watchdog timeout pulse |
| wdog_en | input | 1 | Watchdog enabled level |
| lol_evt | input | 1 | PLL loss-of-lock pulse |
| loc_evt | input | 1 | Loss-of-clock pulse |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data (one clears a flag) |
| reg_rdata | output | 8 | Read data |

## Verification
Every effect of a pulse, a write or a deep event is registered once. It therefore appears on `reg_rdata` one edge after the cycle in which the stimulus was driven. The read path is combinational on `reg_sel`, so `reg_rdata` follows `reg_sel` in the same cycle.

The bench drives each stimulus on the falling edge. It waits for one rising edge and compares one time unit later against a bench model that has been advanced by exactly one step. Directed cases are also compared against fixed byte values.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int FLAG_W = 8;

    localparam int B_POR  = 7;
    localparam int B_PIN  = 6;
    localparam int B_WDOG = 5;
    localparam int B_RSVD = 4;
    localparam int B_LOL  = 3;
    localparam int B_LOC  = 2;
    localparam int B_LVD  = 1;
    localparam int B_WAKE = 0;

    typedef logic [FLAG_W-1:0] flags_t;

    localparam flags_t INIT_POR  = flags_t'((1 << B_POR) | (1 << B_LVD));
    localparam flags_t INIT_LVD  = flags_t'(1 << B_LVD);
    localparam flags_t INIT_WAKE = flags_t'(1 << B_WAKE);
    localparam flags_t RSVD_MASK = flags_t'(1 << B_RSVD);

    typedef enum logic [1:0] {
        DEEP_NONE = 2'd0,
        DEEP_WAKE = 2'd1,
        DEEP_LVD  = 2'd2,
        DEEP_POR  = 2'd3
    } deep_kind_e;

    typedef struct packed {
        flags_t flags;
    } bank_st_t;
endpackage

// File: rtl/rcs_deep_arbiter.sv
module rcs_deep_arbiter
    import rcs_pkg::*;
(
    input  logic       por_evt,
    input  logic       lvd_evt,
    input  logic       wake_evt,
    output deep_kind_e deep_kind,
    output flags_t     deep_init
);
    always_comb begin
        deep_kind = DEEP_NONE;
        deep_init = '0;
        if (por_evt) begin
            deep_kind = DEEP_POR;
            deep_init = INIT_POR;
        end else if (lvd_evt) begin
            deep_kind = DEEP_LVD;
            deep_init = INIT_LVD;
        end else if (wake_evt) begin
            deep_kind = DEEP_WAKE;
            deep_init = INIT_WAKE;
        end
    end
endmodule

// File: rtl/rcs_source_map.sv
module rcs_source_map
    import rcs_pkg::*;
(
    input  logic   pin_evt,
    input  logic   wdog_evt,
    input  logic   wdog_en,
    input  logic   lol_evt,
    input  logic   loc_evt,
    output flags_t set_mask
);
    always_comb begin
        set_mask         = '0;
        set_mask[B_PIN]  = pin_evt;
        set_mask[B_WDOG] = wdog_evt & wdog_en;
        set_mask[B_LOL]  = lol_evt;
        set_mask[B_LOC]  = loc_evt;
    end
endmodule

// File: rtl/rcs_flag_bank.sv
module rcs_flag_bank
    import rcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  deep_kind_e deep_kind,
    input  flags_t     deep_init,
    input  flags_t     set_mask,
    input  flags_t     clr_mask,
    output flags_t     flags_q
);
    bank_st_t st_d, st_q;
    flags_t   warm_d;

    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
        if (b == B_RSVD) begin : g_rsvd
            assign warm_d[b] = 1'b0;
        end else begin : g_flag
            assign warm_d[b] = set_mask[b] | (st_q.flags[b] & ~clr_mask[b]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (deep_kind != DEEP_NONE) begin
            st_d.flags = deep_init;
        end else begin
            st_d.flags = warm_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= INIT_POR;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_kind == DEEP_NONE && set_mask != '0)
        |=> ((flags_q & $past(set_mask)) == $past(set_mask)));

    // R7
    deep_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_kind != DEEP_NONE) |=> (flags_q == $past(deep_init)));

    // R4
    warm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_kind == DEEP_NONE && clr_mask == '0)
        |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_kind == DEEP_NONE && (clr_mask & ~set_mask) != '0)
        |=> ((flags_q & $past(clr_mask & ~set_mask)) == '0));
endmodule

// File: rtl/rst_cause_sticky.sv
module rst_cause_sticky
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_evt,
    input  logic              lvd_evt,
    input  logic              wake_evt,
    input  logic              pin_evt,
    input  logic              wdog_evt,
    input  logic              wdog_en,
    input  logic              lol_evt,
    input  logic              loc_evt,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic [FLAG_W-1:0] reg_rdata
);
    deep_kind_e deep_kind;
    flags_t     deep_init;
    flags_t     set_mask;
    flags_t     clr_mask;
    flags_t     flags_q;

    rcs_deep_arbiter u_deep (
        .por_evt  (por_evt),
        .lvd_evt  (lvd_evt),
        .wake_evt (wake_evt),
        .deep_kind(deep_kind),
        .deep_init(deep_init)
    );

    rcs_source_map u_src (
        .pin_evt (pin_evt),
        .wdog_evt(wdog_evt),
        .wdog_en (wdog_en),
        .lol_evt (lol_evt),
        .loc_evt (loc_evt),
        .set_mask(set_mask)
    );

    always_comb begin
        clr_mask = '0;
        if (reg_sel && reg_wr) begin
            clr_mask = reg_wdata & ~RSVD_MASK;
        end
    end

    rcs_flag_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .deep_kind(deep_kind),
        .deep_init(deep_init),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .flags_q  (flags_q)
    );

    assign reg_rdata = reg_sel ? flags_q : '0;

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[B_RSVD] == 1'b0);

    // R5
    wdog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdog_en && !por_evt && !lvd_evt && !wake_evt && !flags_q[B_WDOG])
        |=> !flags_q[B_WDOG]);

    // R8
    read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata == '0));
endmodule

// File: tb/rst_cause_sticky_bench.sv
`timescale 1ns/1ps
module rst_cause_sticky_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       por_evt, lvd_evt, wake_evt, pin_evt, wdog_evt, wdog_en, lol_evt, loc_evt;
    logic       reg_sel, reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    int         n_vec = 0;
    int         n_bad = 0;
    logic [7:0] exp_flags;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    rst_cause_sticky u_rst_cause_sticky (
        .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .lvd_evt(lvd_evt),
        .wake_evt(wake_evt), .pin_evt(pin_evt), .wdog_evt(wdog_evt),
        .wdog_en(wdog_en), .lol_evt(lol_evt), .loc_evt(loc_evt),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] model_next(
        logic [7:0] cur, logic por, logic lvd, logic wake, logic pin,
        logic wd, logic wden, logic lol, logic loc, logic sel, logic wr,
        logic [7:0] wdata);
        logic [7:0] n;
        if (por)  return 8'h82;
        if (lvd)  return 8'h02;
        if (wake) return 8'h01;
        n = cur;
        if (sel && wr) n = n & ~wdata;
        if (pin) n[6] = 1'b1;
        if (wd && wden) n[5] = 1'b1;
        if (lol) n[3] = 1'b1;
        if (loc) n[2] = 1'b1;
        n[4] = 1'b0;
        return n;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        por_evt = 0; lvd_evt = 0; wake_evt = 0; pin_evt = 0; wdog_evt = 0;
        lol_evt = 0; loc_evt = 0; reg_sel = 1; reg_wr = 0; reg_wdata = '0;
    endtask

    // Drive on the falling edge, compare 1 ns after the next rising edge.
    task automatic step(input logic por, input logic lvd, input logic wake,
                        input logic pin, input logic wd, input logic wden,
                        input logic lol, input logic loc, input logic sel,
                        input logic wr, input logic [7:0] wdata, input string req);
        @(negedge clk);
        por_evt = por; lvd_evt = lvd; wake_evt = wake; pin_evt = pin;
        wdog_evt = wd; wdog_en = wden; lol_evt = lol; loc_evt = loc;
        reg_sel = sel; reg_wr = wr; reg_wdata = wdata;
        exp_flags = model_next(exp_flags, por, lvd, wake, pin, wd, wden, lol, loc, sel, wr, wdata);
        @(posedge clk);
        #1;
        chk(reg_rdata, sel ? exp_flags : 8'h00, req);
    endtask

    task automatic fixed(input logic [7:0] exp, input string req);
        chk(reg_rdata, exp, req);
    endtask

    initial begin
        fork
            begin
                #(5ns * 150000);
                if (!done) begin
                    n_vec++;
                    n_bad++;
                    $display("FAIL watchdog: got 0x00 expected 0x01");
                    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        wdog_en = 1'b1;
        rst_n = 1'b0;
        exp_flags = 8'h82;
        repeat (3) @(posedge clk);
        #1;
        fixed(8'h82, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        fixed(8'h82, "R1 after release");

        step(0,0,0, 0,0,1, 0,0, 1,1,8'hFF, "R3 clear all");
        fixed(8'h00, "R3 cleared");
        step(0,0,0, 1,0,1, 1,0, 1,0,8'h00, "R4 pin+lol");
        fixed(8'h48, "R4 pin+lol");
        step(0,0,0, 0,1,0, 0,0, 1,0,8'h00, "R5 wdog disabled");
        fixed(8'h48, "R5 wdog disabled");
        step(0,0,0, 0,1,1, 0,1, 1,0,8'h00, "R4 wdog+loc");
        fixed(8'h6C, "R4 wdog+loc");
        step(0,0,0, 0,0,1, 0,0, 1,1,8'h00, "R3 write zero");
        fixed(8'h6C, "R3 write zero");
        step(0,0,0, 0,0,1, 0,0, 1,1,8'h10, "R2 write bit4");
        fixed(8'h6C, "R2 write bit4");
        step(0,0,0, 0,0,1, 0,0, 0,1,8'hFF, "R9 unselected write");
        fixed(8'h00, "R8 unselected read");
        step(0,0,0, 0,0,1, 0,0, 1,0,8'h00, "R9 after unselected write");
        fixed(8'h6C, "R9 flags kept");
        step(0,0,0, 0,0,1, 0,0, 1,0,8'h00, "R8 repeat read");
        fixed(8'h6C, "R8 read no side effect");
        step(0,0,0, 1,0,1, 0,0, 1,1,8'h44, "R6 set vs clear");
        fixed(8'h68, "R6 set wins");
        step(0,1,0, 1,1,1, 1,1, 1,0,8'h00, "R7 lvd over warm");
        fixed(8'h02, "R7 lvd");
        step(0,0,1, 0,0,1, 0,0, 1,1,8'hFF, "R7 wake over write");
        fixed(8'h01, "R7 wake");
        step(0,1,1, 0,0,1, 0,0, 1,0,8'h00, "R7 lvd beats wake");
        fixed(8'h02, "R7 lvd beats wake");
        step(1,1,1, 0,0,1, 0,0, 1,0,8'h00, "R7 por priority");
        fixed(8'h82, "R7 por");

        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_flags = 8'h82;
        @(posedge clk);
        #1;
        fixed(8'h82, "R1 second power-on");

        for (int i = 0; i < 3000; i++) begin
            logic deep = ($urandom_range(0, 31) == 0);
            step(deep && ($urandom_range(0, 2) == 0),
                 deep && ($urandom_range(0, 1) == 0),
                 deep && ($urandom_range(0, 1) == 0),
                 $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 1) == 1,
                 $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
                 8'($urandom()), "R4 R6 R7 random");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule